// File: doc/BRIEF.md
# Protected Interrupt Entry Sequencer

This block carries out the hardware side of entering a privileged handler once an interrupt or exception has been taken. Four request sources compete for it: internally detected exceptions, a non-maskable line, software interrupts and a maskable line. Each source supplies an 8-bit vector. The block checks the winning vector against the limit of the descriptor table and reads the 8-byte gate descriptor through a read port that has one cycle of latency. It then compares the privilege level of the handler's selector with the current one.

When the handler runs at a more privileged level, the block fetches a fresh stack pointer and stack selector from a task-state record. It pushes the interrupted context onto that new stack through a word-wide write port, then reports the handler's code selector, instruction pointer, stack selector and stack pointer together with a one-cycle completion pulse. When no switch is needed, the block pushes a shorter frame onto the current stack.

The caller holds the current machine state and the table/record base inputs steady while a request is pending. It reloads its registers from the handler outputs when the completion pulse arrives.

Top module: `irq_entry_seq`

## Requirements
- R1: Simultaneous requests are granted in the order exception, non-maskable, software, maskable. The one-hot `take` output marks the granted source in the cycle it is accepted: bit 3 exception, bit 2 non-maskable, bit 1 software, bit 0 maskable.
- R2: A maskable request is granted only while bit 9 of `cur_flags` is 1. A non-maskable request is granted whatever that bit holds.
- R3: The descriptor is read as two words, at `dtr[47:16] + vector*8` and then at that address plus 4. The handler selector is word0[31:16]. The handler instruction pointer is {word1[31:16], word0[15:0]}.
- R4: If vector*8+7 is greater than `dtr[15:0]`, `fault` pulses for one cycle, in the cycle after acceptance. No read, no write and no `done` follow.
- R5: If selector[1:0] is numerically less than `cur_cs[1:0]`, the block reads the new stack pointer from `tss_base+4` and the new stack selector from the low 16 bits of the word at `tss_base+8`. These reads follow the descriptor reads.
- R6: Each push first lowers the stack pointer by 4 and then writes a 32-bit word at the lowered address. With a switch, the order is: old stack selector, old stack pointer, flags, old code selector, old instruction pointer. Selectors are zero-extended.
- R7: Without a switch, no task-state reads occur. Only flags, code selector and instruction pointer are pushed, below `cur_sp`, and the handler stack selector equals `cur_ss`.
- R8: An error code word (`exc_err`) is pushed last only when an exception is granted with `exc_has_err` high. No other source ever pushes one.
- R9: `done` is a single-cycle pulse. While it is high, `hnd_cs`, `hnd_ip`, `hnd_ss` and `hnd_sp` hold the selector, the instruction pointer, the new stack selector and the final stack pointer.
- R10: One memory read is issued per cycle, and its data is consumed in the next cycle. `done` rises 4 + 2·S + P cycles after the acceptance edge, where S is 1 for a switch and P is the number of pushes.
- R11: Requests that arrive while `busy` is high are ignored: `take` stays 0 and no extra memory traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Internal exception request |
| exc_vec | input | 8 | Exception vector |
| exc_has_err | input | 1 | Exception carries an error code |
| exc_err | input | 32 | Error code word |
| nmi_req | input | 1 | Non-maskable request |
| nmi_vec | input | 8 | Non-maskable vector |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | 8 | Software interrupt vector (instruction operand) |
| intr_req | input | 1 | Maskable request |
| intr_vec | input | 8 | Vector from the interrupt controller |
| dtr | input | 48 | Table base [47:16], table limit [15:0] |
| tss_base | input | 32 | Task-state record address |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Current instruction pointer |
| cur_flags | input | 32 | Current flags (bit 9 enables maskable requests) |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| take | output | 4 | One-hot grant in the acceptance cycle |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 32 | Memory read address |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 32 | Memory write data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Handler state is loaded (one cycle) |
| fault | output | 1 | Vector outside the table limit (one cycle) |
| hnd_cs | output | 16 | Handler code selector |
| hnd_ip | output | 32 | Handler instruction pointer |
| hnd_ss | output | 16 | Handler stack selector |
| hnd_sp | output | 32 | Handler stack pointer |

## Verification
The grant appears combinationally in the acceptance cycle, so the bench samples `take` just before that edge. A limit fault is due one cycle after acceptance. Every read and write is due in a fixed slot of the sequence, and completion is due exactly 4 + 2·S + P cycles after acceptance. The bench counts clock edges from the accepting edge, compares the count with the figure it derives from the descriptor and task-state contents it planted, and samples at the falling edge. A monitor pops each expected read address and write word in order as the strobes appear, so any shift by a cycle or reordering shows as a mismatch.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    parameter int AW    = 32;
    parameter int VW    = 8;
    parameter int SELW  = 16;
    parameter int NSRC  = 4;
    parameter int WBYTE = 4;
    parameter int IF_BIT = 9;
    localparam int ENTRY_SHIFT = 3;
    localparam int IDXW = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_DEC, S_TS1, S_TS2, S_PUSH, S_LOAD, S_FLT
    } seq_state_t;

    typedef struct packed {
        logic [SELW-1:0] cs;
        logic [AW-1:0]   ip;
        logic [AW-1:0]   flags;
        logic [SELW-1:0] ss;
        logic [AW-1:0]   sp;
    } ctx_t;

    // push slot 0..5 : ss, sp, flags, cs, ip, error code
    function automatic logic [AW-1:0] push_word(input logic [IDXW-1:0] idx,
                                                input ctx_t c,
                                                input logic [AW-1:0] err);
        case (idx)
            3'd0:    push_word = AW'(c.ss);
            3'd1:    push_word = c.sp;
            3'd2:    push_word = c.flags;
            3'd3:    push_word = AW'(c.cs);
            3'd4:    push_word = c.ip;
            default: push_word = err;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb
    import irq_entry_pkg::*;
(
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC*VW-1:0]     vecs,
    output logic [NSRC-1:0]        grant,
    output logic [VW-1:0]          vec
);
    // highest index has highest priority
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = vecs[i*VW +: VW];
            end
        end
    end
endmodule

// File: rtl/irq_desc_addr.sv
module irq_desc_addr
    import irq_entry_pkg::*;
(
    input  logic [47:0]   dtr,
    input  logic [VW-1:0] vec,
    output logic [AW-1:0] addr,
    output logic          in_range
);
    localparam int OFFW = VW + ENTRY_SHIFT;
    logic [OFFW-1:0] off;
    logic [OFFW:0]   last_byte;

    always_comb begin
        off       = OFFW'(vec) << ENTRY_SHIFT;
        last_byte = {1'b0, off} + (OFFW+1)'(7);
        addr      = dtr[47:16] + AW'(off);
        in_range  = (17'(last_byte) <= {1'b0, dtr[15:0]});
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_req,
    input  logic [7:0]  exc_vec,
    input  logic        exc_has_err,
    input  logic [31:0] exc_err,
    input  logic        nmi_req,
    input  logic [7:0]  nmi_vec,
    input  logic        swi_req,
    input  logic [7:0]  swi_vec,
    input  logic        intr_req,
    input  logic [7:0]  intr_vec,
    input  logic [47:0] dtr,
    input  logic [31:0] tss_base,
    input  logic [15:0] cur_cs,
    input  logic [31:0] cur_ip,
    input  logic [31:0] cur_flags,
    input  logic [15:0] cur_ss,
    input  logic [31:0] cur_sp,
    output logic [3:0]  take,
    output logic        rd_en,
    output logic [31:0] rd_addr,
    input  logic [31:0] rd_data,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic        fault,
    output logic [15:0] hnd_cs,
    output logic [31:0] hnd_ip,
    output logic [15:0] hnd_ss,
    output logic [31:0] hnd_sp
);
    localparam logic [IDXW-1:0] FIRST_SW = 3'd0;
    localparam logic [IDXW-1:0] FIRST_NS = 3'd2;
    localparam logic [IDXW-1:0] LAST_ERR = 3'd5;
    localparam logic [IDXW-1:0] LAST_STD = 3'd4;

    seq_state_t st;
    ctx_t       ctx_q;
    logic [AW-1:0]   daddr_q, dlo_q, tss_q, err_q, sp_q, ip_q;
    logic [SELW-1:0] sel_q, nss_q;
    logic [IDXW-1:0] idx_q, last_q;

    logic [NSRC-1:0]    req_v, grant;
    logic [VW-1:0]      win_vec;
    logic [AW-1:0]      daddr;
    logic               in_range;
    logic               intr_ok;
    logic [SELW-1:0]    dec_sel;
    logic               dec_sw;

    assign intr_ok = intr_req & cur_flags[IF_BIT];
    assign req_v   = (st == S_IDLE) ? {exc_req, nmi_req, swi_req, intr_ok} : '0;

    irq_src_arb u_arb (
        .req   (req_v),
        .vecs  ({exc_vec, nmi_vec, swi_vec, intr_vec}),
        .grant (grant),
        .vec   (win_vec)
    );

    irq_desc_addr u_addr (
        .dtr      (dtr),
        .vec      (win_vec),
        .addr     (daddr),
        .in_range (in_range)
    );

    assign take    = grant;
    assign dec_sel = dlo_q[31:16];
    assign dec_sw  = dec_sel[1:0] < ctx_q.cs[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ctx_q  <= '0;
            daddr_q <= '0; dlo_q <= '0; tss_q <= '0; err_q <= '0;
            sp_q   <= '0; ip_q  <= '0; sel_q <= '0; nss_q <= '0;
            idx_q  <= '0; last_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (|grant) begin
                    ctx_q   <= '{cs: cur_cs, ip: cur_ip, flags: cur_flags,
                                 ss: cur_ss, sp: cur_sp};
                    daddr_q <= daddr;
                    tss_q   <= tss_base;
                    err_q   <= exc_err;
                    last_q  <= (grant[3] && exc_has_err) ? LAST_ERR : LAST_STD;
                    st      <= in_range ? S_RD0 : S_FLT;
                end
                S_RD0: st <= S_RD1;
                S_RD1: begin
                    dlo_q <= rd_data;
                    st    <= S_DEC;
                end
                S_DEC: begin
                    sel_q <= dec_sel;
                    ip_q  <= {rd_data[31:16], dlo_q[15:0]};
                    if (dec_sw) begin
                        idx_q <= FIRST_SW;
                        st    <= S_TS1;
                    end else begin
                        idx_q <= FIRST_NS;
                        sp_q  <= ctx_q.sp;
                        nss_q <= ctx_q.ss;
                        st    <= S_PUSH;
                    end
                end
                S_TS1: begin
                    sp_q <= rd_data;
                    st   <= S_TS2;
                end
                S_TS2: begin
                    nss_q <= rd_data[SELW-1:0];
                    st    <= S_PUSH;
                end
                S_PUSH: begin
                    sp_q  <= sp_q - AW'(WBYTE);
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == last_q) st <= S_LOAD;
                end
                S_LOAD:  st <= S_IDLE;
                S_FLT:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        case (st)
            S_RD0: begin rd_en = 1'b1; rd_addr = daddr_q; end
            S_RD1: begin rd_en = 1'b1; rd_addr = daddr_q + AW'(WBYTE); end
            S_DEC: if (dec_sw) begin rd_en = 1'b1; rd_addr = tss_q + AW'(WBYTE); end
            S_TS1: begin rd_en = 1'b1; rd_addr = tss_q + AW'(2*WBYTE); end
            default: ;
        endcase
    end

    assign wr_en   = (st == S_PUSH);
    assign wr_addr = sp_q - AW'(WBYTE);
    assign wr_data = push_word(idx_q, ctx_q, err_q);

    assign busy   = (st != S_IDLE);
    assign done   = (st == S_LOAD);
    assign fault  = (st == S_FLT);
    assign hnd_cs = sel_q;
    assign hnd_ip = ip_q;
    assign hnd_ss = nss_q;
    assign hnd_sp = sp_q;

    // R1
    take_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(take));
    // R2
    intr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (take[0] |-> cur_flags[IF_BIT]));
    // R4
    fault_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (fault |-> !rd_en && !wr_en && !done));
    // R6
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) - 32'd4));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done |=> !done && !busy));
    // R11
    busy_take_chk: assert property (@(posedge clk) disable iff (rst)
        (busy |-> take == 4'b0000));
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        exc_req = 0, exc_has_err = 0, nmi_req = 0, swi_req = 0, intr_req = 0;
    logic [7:0]  exc_vec = 0, nmi_vec = 0, swi_vec = 0, intr_vec = 0;
    logic [31:0] exc_err = 0;
    logic [47:0] dtr = 0;
    logic [31:0] tss_base = 0;
    logic [15:0] cur_cs = 0, cur_ss = 0;
    logic [31:0] cur_ip = 0, cur_flags = 0, cur_sp = 0;
    logic [3:0]  take;
    logic        rd_en, wr_en, busy, done, fault;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [31:0] rd_data = 0;
    logic [15:0] hnd_cs, hnd_ss;
    logic [31:0] hnd_ip, hnd_sp;

    int errors = 0;
    int checks = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rdq [$];
    logic [63:0] wrq [$];

    irq_entry_seq u_irq_entry_seq (
        .clk, .rst, .exc_req, .exc_vec, .exc_has_err, .exc_err,
        .nmi_req, .nmi_vec, .swi_req, .swi_vec, .intr_req, .intr_vec,
        .dtr, .tss_base, .cur_cs, .cur_ip, .cur_flags, .cur_ss, .cur_sp,
        .take, .rd_en, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data,
        .busy, .done, .fault, .hnd_cs, .hnd_ip, .hnd_ss, .hnd_sp
    );

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= rdm(rd_addr);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected traffic as it appears
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            if (rdq.size() == 0) chk(0, "R3/R5/R11 unexpected read", {32'h0, rd_addr}, 64'h0);
            else begin
                logic [31:0] e;
                e = rdq.pop_front();
                chk(rd_addr == e, "R3/R5/R10 read address", {32'h0, rd_addr}, {32'h0, e});
            end
        end
        if (!rst && wr_en) begin
            if (wrq.size() == 0) chk(0, "R6/R11 unexpected write", {wr_addr, wr_data}, 64'h0);
            else begin
                logic [63:0] e;
                e = wrq.pop_front();
                chk({wr_addr, wr_data} == e, "R6/R7/R8 push", {wr_addr, wr_data}, e);
            end
        end
    end

    function automatic void put_desc(input logic [7:0] v, input logic [15:0] sel, input logic [31:0] ip);
        logic [31:0] a;
        a = dtr[47:16] + {21'h0, v, 3'b0};
        mem[a]     = {sel, ip[15:0]};
        mem[a + 4] = {ip[31:16], 16'h8e00};
    endfunction

    // driver: mask bits 3 exc,2 nmi,1 swi,0 intr ; win = expected grant (0 = none)
    task automatic run(input logic [3:0] mask, input logic [3:0] win, input string tag, input bit poke_busy);
        logic [7:0]  v;
        logic [31:0] a, w0, w1, sp, ip;
        logic [15:0] sel, ss;
        bit sw, flt, herr;
        int n, cnt, exp_cnt;
        v    = win[3] ? exc_vec : win[2] ? nmi_vec : win[1] ? swi_vec : intr_vec;
        herr = win[3] && exc_has_err;
        a    = dtr[47:16] + {21'h0, v, 3'b0};
        flt  = ({21'h0, v, 3'b0} + 32'd7) > {16'h0, dtr[15:0]};
        if (win != 0 && !flt) begin
            w0 = rdm(a); w1 = rdm(a + 4);
            sel = w0[31:16]; ip = {w1[31:16], w0[15:0]};
            sw  = sel[1:0] < cur_cs[1:0];
            rdq.push_back(a); rdq.push_back(a + 4);
            if (sw) begin
                rdq.push_back(tss_base + 4); rdq.push_back(tss_base + 8);
                sp = rdm(tss_base + 4); ss = rdm(tss_base + 8) & 32'hffff;
                sp -= 4; wrq.push_back({sp, 16'h0, cur_ss});
                sp -= 4; wrq.push_back({sp, cur_sp});
                n = 2;
            end else begin
                sp = cur_sp; ss = cur_ss; n = 0;
            end
            sp -= 4; wrq.push_back({sp, cur_flags});
            sp -= 4; wrq.push_back({sp, 16'h0, cur_cs});
            sp -= 4; wrq.push_back({sp, cur_ip});
            n += 3;
            if (herr) begin sp -= 4; wrq.push_back({sp, exc_err}); n++; end
            exp_cnt = 4 + (sw ? 2 : 0) + n;
        end
        @(negedge clk);
        {exc_req, nmi_req, swi_req, intr_req} = mask;
        #1;
        chk(take == win, {tag, " R1/R2 grant"}, {60'h0, take}, {60'h0, win});
        cnt = 0;
        forever begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (cnt == 1) {exc_req, nmi_req, swi_req, intr_req} = 4'b0;
            if (poke_busy && cnt == 3) begin
                nmi_req = 1;
                #1 chk(take == 4'b0 && busy, {tag, " R11 ignored while busy"}, {60'h0, take}, 64'h0);
            end
            if (poke_busy && cnt == 4) nmi_req = 0;
            if (done || fault || cnt > 40 || (win == 0 && cnt == 6)) break;
        end
        if (win == 0) begin
            chk(!busy && !done && !fault, {tag, " R2 masked request ignored"}, {61'h0, busy, done, fault}, 64'h0);
        end else if (flt) begin
            chk(fault && cnt == 1, {tag, " R4 fault timing"}, cnt, 1);
            @(negedge clk);
            chk(!fault && !busy, {tag, " R4 fault single pulse"}, {62'h0, fault, busy}, 64'h0);
        end else begin
            chk(done && cnt == exp_cnt, {tag, " R10 done timing"}, cnt, exp_cnt);
            chk({hnd_cs, hnd_ip, hnd_ss} == {sel, ip, ss}, {tag, " R9 handler state"},
                {hnd_cs, hnd_ip, hnd_ss}, {sel, ip, ss});
            chk(hnd_sp == sp, {tag, " R5/R7 handler stack pointer"}, hnd_sp, sp);
            @(negedge clk);
            chk(!done, {tag, " R9 done single pulse"}, done, 0);
        end
        repeat (4) @(negedge clk);
        chk(rdq.size() == 0 && wrq.size() == 0, {tag, " R10 all traffic seen"},
            rdq.size(), wrq.size());
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        dtr      = {32'h0001_0000, 16'h07ff};
        tss_base = 32'h0002_0000;
        mem[tss_base + 4] = 32'h0009_0000;
        mem[tss_base + 8] = 32'hdead_0010;
        cur_cs = 16'h001b; cur_ss = 16'h0023; cur_ip = 32'h0040_1234;
        cur_sp = 32'h7fff_f000; cur_flags = 32'h0000_0202;
        put_desc(8'd13,  16'h0008, 32'hc010_1000);
        put_desc(8'd2,   16'h0008, 32'hc010_2000);
        put_desc(8'h80,  16'h000b, 32'h0050_3000);
        put_desc(8'h20,  16'h0008, 32'hc010_4000);
        put_desc(8'h1f,  16'h0008, 32'hc010_5000);

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        chk(!busy && !done && !fault && !rd_en && !wr_en, "R9 reset idle",
            {59'h0, busy, done, fault, rd_en, wr_en}, 64'h0);

        exc_vec = 8'd13; nmi_vec = 8'd2; swi_vec = 8'h80; intr_vec = 8'h20;
        exc_has_err = 1; exc_err = 32'h0000_0abc;

        run(4'b1000, 4'b1000, "exc+err switch", 0);          // R5 R6 R8
        run(4'b1111, 4'b1000, "all four", 0);                 // R1
        run(4'b0111, 4'b0100, "nmi over swi", 1);             // R1 R11
        run(4'b0011, 4'b0010, "swi no switch", 0);            // R7
        run(4'b0001, 4'b0001, "intr enabled", 0);             // R2
        cur_flags = 32'h0000_0002;
        run(4'b0001, 4'b0000, "intr masked", 0);              // R2
        run(4'b0101, 4'b0100, "nmi while masked", 0);         // R2
        exc_has_err = 0;
        run(4'b1000, 4'b1000, "exc no err", 0);               // R8
        cur_cs = 16'h0008; cur_ss = 16'h0010; cur_sp = 32'h0008_8000;
        exc_has_err = 1;
        run(4'b1000, 4'b1000, "exc kernel no switch", 0);     // R7 R8
        dtr[15:0] = 16'h00ff;
        exc_vec = 8'h1f;
        run(4'b1000, 4'b1000, "limit edge ok", 0);            // R4 boundary
        exc_vec = 8'h20;
        run(4'b1000, 4'b1000, "limit exceeded", 0);           // R4

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule